// File: doc/BRIEF.md
# Keyboard Key Event Tracker

This block reads scan-code bytes, one at a time, from an upstream byte queue that sits behind a serial keyboard receiver. When the queue shows a byte, the tracker takes it and gives the queue a one-cycle active-low acknowledge. It then reads the byte as part of a scan-code-set-2 key event. A single byte is the code of a key being pressed. The pair F0h followed by that code means the key was released.

Only one key is followed at a time. While the key is down, the tracker shows its scan code, the ASCII character for that code, and a key-active flag. The flag lets a display driver blank its digits when no key is down. An 8-bit counter goes up once per distinct press. Typematic repeats of a held key leave the count unchanged, so holding a key adds one and no more.

Top module: `kbd_key_tracker`

## Requirements
- R1: While `rst` is high on a clock edge, and after that edge, `byte_ack_n` is 1, `key_code` and `key_ascii` are 00h, `key_active` is 0 and `press_count` is 00h.
- R2: A byte is taken on an edge where `byte_rdy` is 1 and `byte_ack_n` is 1. After that edge, `byte_ack_n` is 0 for exactly one cycle. While `byte_rdy` is held at 1, bytes are therefore taken on every second edge. No acknowledge is given while `byte_rdy` is 0.
- R3: A byte other than F0h taken with no key held marks that code as pressed. After the same edge, `key_code` shows the byte, `key_active` is 1 and `press_count` has gone up by one.
- R4: While a key is held, a byte other than F0h changes no output and does not count. This covers a repeat of the held code and also any other code.
- R5: An F0h byte taken while a key is held leaves every output unchanged. The tracker then waits for the byte that completes the release.
- R6: The byte taken after that F0h ends the hold. After that edge, `key_active` is 0, `key_code` and `key_ascii` are 00h, and `press_count` is unchanged.
- R7: An F0h byte taken while no key is held is ignored, and all outputs keep their values.
- R8: `key_ascii` gives the ASCII value of the held key:
  - letter keys map to uppercase 41h–5Ah;
  - digit keys map to 30h–39h;
  - examples: 1Ch→41h, 1Bh→53h, 1Dh→57h, 1Ah→5Ah, 45h→30h, 16h→31h.
- R9: A held scan code with no character entry, for example 05h, gives `key_ascii` 00h. It is still shown as active and still counted.
- R10: `press_count` wraps from FFh to 00h on the next press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_rdy | input | 1 | Upstream queue has a byte available |
| byte_data | input | 8 | Byte at the head of the upstream queue |
| byte_ack_n | output | 1 | Active-low, one-cycle acknowledge that advances the queue |
| key_code | output | 8 | Scan code of the held key, 00h when none is held |
| key_ascii | output | 8 | ASCII value of the held key, 00h when none is held or when the code has no entry |
| key_active | output | 1 | A key is currently held |
| press_count | output | CNT_W (8) | Number of distinct presses, wrapping |

## Verification
Two things can happen on the same edge: the counter rolls over from FFh to 00h, and the key-active flag rises for a new press. The bench provokes this by running enough press-and-release cycles to reach a count of FFh, then pressing one more key. It judges the result by requiring, after that edge, a count of 00h together with the flag high and the new code shown.

A second overlap comes from holding `byte_rdy` high while the held code repeats. On the same edges, the acknowledge toggles and the repeated bytes arrive. The bench checks that exactly every other cycle is acknowledged, and that the count does not move.

// File: rtl/kbd_trk_pkg.sv
package kbd_trk_pkg;

    localparam int KB_W = 8;
    localparam logic [KB_W-1:0] BREAK_CODE = 8'hF0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_BRK  = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic            valid;
        logic [KB_W-1:0] data;
    } kbd_byte_t;

    function automatic logic [KB_W-1:0] scan_to_ascii(input logic [KB_W-1:0] sc);
        logic [KB_W-1:0] a;
        case (sc)
            8'h1C: a = 8'h41; 8'h32: a = 8'h42; 8'h21: a = 8'h43; 8'h23: a = 8'h44;
            8'h24: a = 8'h45; 8'h2B: a = 8'h46; 8'h34: a = 8'h47; 8'h33: a = 8'h48;
            8'h43: a = 8'h49; 8'h3B: a = 8'h4A; 8'h42: a = 8'h4B; 8'h4B: a = 8'h4C;
            8'h3A: a = 8'h4D; 8'h31: a = 8'h4E; 8'h44: a = 8'h4F; 8'h4D: a = 8'h50;
            8'h15: a = 8'h51; 8'h2D: a = 8'h52; 8'h1B: a = 8'h53; 8'h2C: a = 8'h54;
            8'h3C: a = 8'h55; 8'h2A: a = 8'h56; 8'h1D: a = 8'h57; 8'h22: a = 8'h58;
            8'h35: a = 8'h59; 8'h1A: a = 8'h5A;
            8'h45: a = 8'h30; 8'h16: a = 8'h31; 8'h1E: a = 8'h32; 8'h26: a = 8'h33;
            8'h25: a = 8'h34; 8'h2E: a = 8'h35; 8'h36: a = 8'h36; 8'h3D: a = 8'h37;
            8'h3E: a = 8'h38; 8'h46: a = 8'h39;
            default: a = 8'h00;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/kbd_byte_reader.sv
module kbd_byte_reader
    import kbd_trk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rdy,
    input  logic [KB_W-1:0] din,
    output logic            ack_n,
    output kbd_byte_t       evt
);

    logic ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= rdy & ~ack_q;
    end

    assign ack_n      = ~ack_q;
    assign evt.valid  = rdy & ~ack_q;
    assign evt.data   = din;

    // R2: acknowledge low for exactly one cycle
    p_ack_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        !ack_n |=> ack_n);

    // R2: acknowledge only follows a ready byte
    p_ack_needs_ready_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n) |-> $past(rdy));

endmodule

// File: rtl/kbd_event_fsm.sv
module kbd_event_fsm
    import kbd_trk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  kbd_byte_t       evt,
    output logic [KB_W-1:0] code,
    output logic            active,
    output logic            press
);

    trk_state_e      st_q, st_d;
    logic [KB_W-1:0] code_q, code_d;
    logic            is_brk;

    assign is_brk = (evt.data == BREAK_CODE);

    always_comb begin
        st_d   = st_q;
        code_d = code_q;
        press  = 1'b0;
        if (evt.valid) begin
            case (st_q)
                ST_IDLE: begin
                    if (!is_brk) begin
                        st_d   = ST_HELD;
                        code_d = evt.data;
                        press  = 1'b1;
                    end
                end
                ST_HELD: begin
                    if (is_brk) st_d = ST_BRK;
                end
                ST_BRK: begin
                    st_d   = ST_IDLE;
                    code_d = '0;
                end
                default: begin
                    st_d   = ST_IDLE;
                    code_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            code_q <= '0;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
        end
    end

    assign code   = code_q;
    assign active = (st_q != ST_IDLE);

    // R6: no key held means the shown code is cleared
    p_idle_code_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !active |-> code == '0);

    // R4: a held code stays put until the release completes
    p_code_stable_held_r4: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(code));

endmodule

// File: rtl/kbd_ascii_rom.sv
module kbd_ascii_rom
    import kbd_trk_pkg::*;
(
    input  logic [KB_W-1:0] code,
    input  logic            active,
    output logic [KB_W-1:0] ascii
);

    assign ascii = active ? scan_to_ascii(code) : '0;

endmodule

// File: rtl/kbd_press_counter.sv
module kbd_press_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    // R3 / R10: each press adds one, modulo the counter width
    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        inc |=> count == CNT_W'($past(count) + 1'b1));

endmodule

// File: rtl/kbd_key_tracker.sv
module kbd_key_tracker
    import kbd_trk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_rdy,
    input  logic [7:0]       byte_data,
    output logic             byte_ack_n,
    output logic [7:0]       key_code,
    output logic [7:0]       key_ascii,
    output logic             key_active,
    output logic [CNT_W-1:0] press_count
);

    kbd_byte_t evt;
    logic      press;

    kbd_byte_reader u_reader (
        .clk   (clk),
        .rst   (rst),
        .rdy   (byte_rdy),
        .din   (byte_data),
        .ack_n (byte_ack_n),
        .evt   (evt)
    );

    kbd_event_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .code   (key_code),
        .active (key_active),
        .press  (press)
    );

    kbd_ascii_rom u_rom (
        .code   (key_code),
        .active (key_active),
        .ascii  (key_ascii)
    );

    kbd_press_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (press),
        .count (press_count)
    );

    // R4: the count only moves when a new press begins
    p_count_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (press_count != $past(press_count)) |-> $rose(key_active));

    // R6: blanked character when no key is held
    p_ascii_blank_r6: assert property (@(posedge clk) disable iff (rst)
        !key_active |-> key_ascii == 8'h00);

endmodule

// File: tb/kbd_key_tracker_test.sv
module kbd_key_tracker_test;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_rdy = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_ack_n;
    logic [7:0] key_code, key_ascii, press_count;
    logic       key_active;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] code;
        logic [7:0] ascii;
        bit         act;
        logic [7:0] cnt;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #(PERIOD/2) clk = ~clk;

    kbd_key_tracker uut (
        .clk         (clk),
        .rst         (rst),
        .byte_rdy    (byte_rdy),
        .byte_data   (byte_data),
        .byte_ack_n  (byte_ack_n),
        .key_code    (key_code),
        .key_ascii   (key_ascii),
        .key_active  (key_active),
        .press_count (press_count)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expectation per acknowledged byte
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && byte_ack_n == 1'b0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected ack", 0, 1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(key_code == e.code, e.tag, "key_code", key_code, e.code);
                    chk(key_ascii == e.ascii, e.tag, "key_ascii", key_ascii, e.ascii);
                    chk(key_active == e.act, e.tag, "key_active", key_active, e.act);
                    chk(press_count == e.cnt, e.tag, "press_count", press_count, e.cnt);
                end
            end
        end
    end

    task automatic push(input logic [7:0] c, input logic [7:0] a, input bit act,
                        input logic [7:0] n, input string tag);
        exp_t e;
        e.code = c; e.ascii = a; e.act = act; e.cnt = n; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send(input logic [7:0] b, input logic [7:0] c, input logic [7:0] a,
                        input bit act, input logic [7:0] n, input string tag);
        push(c, a, act, n, tag);
        @(negedge clk);
        byte_rdy  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_rdy  = 1'b0;
        chk(byte_ack_n == 1'b0, "R2", "ack low after take", byte_ack_n, 0);
        @(negedge clk);
        chk(byte_ack_n == 1'b1, "R2", "ack one cycle", byte_ack_n, 1);
    endtask

    task automatic press_release(input logic [7:0] c, input logic [7:0] a, input string tag);
        logic [7:0] n;
        exp_cnt++;
        n = exp_cnt[7:0];
        send(c, c, a, 1'b1, n, tag);
        send(8'hF0, c, a, 1'b1, n, "R5");
        send(c, 8'h00, 8'h00, 1'b0, n, "R6");
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is asserted
        chk(byte_ack_n == 1'b1, "R1", "ack", byte_ack_n, 1);
        chk(key_code == 8'h00, "R1", "key_code", key_code, 0);
        chk(key_ascii == 8'h00, "R1", "key_ascii", key_ascii, 0);
        chk(key_active == 1'b0, "R1", "key_active", key_active, 0);
        chk(press_count == 8'h00, "R1", "press_count", press_count, 0);
        rst = 1'b0;

        // R2: no acknowledge while nothing is ready
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(byte_ack_n == 1'b1, "R2", "idle ack", byte_ack_n, 1);
        end

        // R7: stray break marker while idle
        send(8'hF0, 8'h00, 8'h00, 1'b0, 8'h00, "R7");

        // R3 / R8: press A
        exp_cnt = 1;
        send(8'h1C, 8'h1C, 8'h41, 1'b1, 8'h01, "R3");
        // R4: repeat of held key and a foreign code
        send(8'h1C, 8'h1C, 8'h41, 1'b1, 8'h01, "R4");
        send(8'h1B, 8'h1C, 8'h41, 1'b1, 8'h01, "R4");
        send(8'hF0, 8'h1C, 8'h41, 1'b1, 8'h01, "R5");
        send(8'h1C, 8'h00, 8'h00, 1'b0, 8'h01, "R6");

        // R2 / R4: ready held high with a repeating code
        begin
            int lows;
            lows = 0;
            exp_cnt = 2;
            push(8'h1C, 8'h41, 1'b1, 8'h02, "R3");
            push(8'h1C, 8'h41, 1'b1, 8'h02, "R4");
            push(8'h1C, 8'h41, 1'b1, 8'h02, "R4");
            @(negedge clk);
            byte_rdy  = 1'b1;
            byte_data = 8'h1C;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (byte_ack_n == 1'b0) lows++;
            end
            byte_rdy = 1'b0;
            chk(lows == 3, "R2", "acks in burst", lows, 3);
            send(8'hF0, 8'h1C, 8'h41, 1'b1, 8'h02, "R5");
            send(8'h1C, 8'h00, 8'h00, 1'b0, 8'h02, "R6");
        end

        // R8: character mapping
        press_release(8'h1B, 8'h53, "R8");
        press_release(8'h1D, 8'h57, "R8");
        press_release(8'h45, 8'h30, "R8");
        press_release(8'h16, 8'h31, "R8");
        press_release(8'h1A, 8'h5A, "R8");
        // R9: code with no character entry
        press_release(8'h05, 8'h00, "R9");

        // R10: run up to FFh, then wrap on one more press
        while (exp_cnt < 255) press_release(8'h24, 8'h45, "R3");
        press_release(8'h1D, 8'h57, "R10");
        chk(press_count == 8'h00, "R10", "count after wrap", press_count, 0);

        @(negedge clk);
        chk(exp_q.size() == 0, "R2", "pending expectations", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule